// File: doc/BRIEF.md
# Soft Reset and Reset-Cause Controller

This block is the reset manager of a board with four processors. Software uses a small byte-wide register port to request power-on resets (POR) for single processors or for the whole system, and externally initiated resets (XIR) for processors. Hardware lines from a watchdog, push buttons, a JTAG reset path, power-up detection, a remote monitor, seven fatal-error sources and the clock-synthesizer control path can also trigger resets. Every reset is a fixed-width pulse of `PULSE_W` clocks.

Two cause registers record which events started the most recent POR and the most recent XIR. Software can read them after the reset. A policy bit sets whether the watchdog line resets the system or is ignored. A quiesce mask turns off fatal-error reporting from each processor separately.

Outside lines are edge-sensitive: only a low-to-high change of a line counts as an event. POR and XIR each have their own pulse engine, so one of each can run at the same time. While an engine is running, new events of its kind are dropped.

Top module: `reset_cause_ctrl`

## Requirements
- R1: After reset, all reset outputs are low and every register address reads 0x00.
- R2: Writing address 0x2 (soft POR) while no POR pulse is running starts a POR pulse on the next clock. If data bits 3:0 are nonzero and bit 4 is zero, `por_o[n]` follows data bit n for exactly `PULSE_W` cycles and the POR cause becomes exactly those bits. During the pulse address 0x2 reads back data bits 4:0. It reads 0 after the pulse ends.
- R3: Soft POR data bit 4, and every other system-level source, drives `sys_rst_o` high and all four `por_o` bits high for the pulse. Bit 4 sets POR cause bit 4.
- R4: Writing address 0x3 (soft XIR) with bits 3:0 nonzero pulses `xir_o[n]` for data bit n for `PULSE_W` cycles. It sets XIR cause bits 3:0 to match. Address 0x3 reads back the request during the pulse and 0 after it.
- R5: A rising `jtag_xir_i` pulses all four `xir_o` bits and sets XIR cause bit 4. A rising `xir_btn_i` does the same and sets XIR cause bit 5.
- R6: A rising `wdog_i` starts a system reset with POR cause bit 16 only when address 0x0 bit 0 is set. When that bit is clear the watchdog line has no effect.
- R7: Each of these rising lines starts a system reset and sets its POR cause bit: `jtag_por_i` bit 5, `rst_btn_i` bit 6, `fatal_i[k]` bit 8+k, `rmon_i` bit 17.
- R8: Address 0x1 is the quiesce byte. When bit 4+n is set, a rising `fatal_i[n]` (n = 0..3) starts no reset and sets no cause bit. `fatal_i[6:4]` cannot be masked.
- R9: Address 0x4 holds an arm bit (bit 7) and a load bit (bit 0). When both become set, a system reset starts with POR cause bit 15. The pulse begins two clocks after the write.
- R10: A rising `pwr_up_i` starts a system reset. The POR cause then reads exactly 0x00080, even if other sources fire in the same cycle.
- R11: Every new reset clears its cause register and sets only the bits of that event's sources. Sources that fire in the same cycle all set their bits together.
- R12: While a pulse of one kind is running, new events of that kind and writes to its soft request address are ignored. The pulse length and the cause do not change.
- R13: POR cause reads as bytes at 0x5 (bits 7:0), 0x6 (bits 15:8) and 0x7 (bits 17:16 in data bits 1:0). XIR cause reads at 0x8 in bits 5:0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| wdog_i | input | 1 | Watchdog expiry line |
| rst_btn_i | input | 1 | System reset push button |
| xir_btn_i | input | 1 | XIR push button |
| jtag_por_i | input | 1 | JTAG system reset request |
| jtag_xir_i | input | 1 | JTAG XIR request |
| pwr_up_i | input | 1 | Power-up indication |
| fatal_i | input | 7 | Fatal-error lines; bits 3:0 come from processors 0..3 |
| rmon_i | input | 1 | Remote monitor reset request |
| por_o | output | 4 | Per-processor power-on reset |
| xir_o | output | 4 | Per-processor externally initiated reset |
| sys_rst_o | output | 1 | System-wide reset |

## Verification
The case most likely to go wrong is a cause capture where several sources land in the same clock. One example is power-up arriving together with a JTAG reset and a fatal error. Another is a soft XIR write together with both XIR lines. Another is a new event arriving while a pulse of the same kind is already running. The bench forces each of these by driving the lines and the register write in one cycle. A behavioural model predicts, clock by clock, the pulse outputs and the byte on the currently addressed register. The expected cause (union of the sources, power-up alone, or unchanged while busy) is then read back through the register port.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    localparam int NCPU   = 4;
    localparam int NFATAL = 7;
    localparam int POR_CW = 18;
    localparam int XIR_CW = 6;

    // register addresses
    localparam logic [3:0] A_WDOG = 4'h0;
    localparam logic [3:0] A_QUI  = 4'h1;
    localparam logic [3:0] A_SPOR = 4'h2;
    localparam logic [3:0] A_SXIR = 4'h3;
    localparam logic [3:0] A_SYN  = 4'h4;
    localparam logic [3:0] A_PC0  = 4'h5;
    localparam logic [3:0] A_PC1  = 4'h6;
    localparam logic [3:0] A_PC2  = 4'h7;
    localparam logic [3:0] A_XC   = 4'h8;

    // POR cause bit positions
    localparam int PB_SYS  = 4;
    localparam int PB_JTAG = 5;
    localparam int PB_BTN  = 6;
    localparam int PB_PWR  = 7;
    localparam int PB_FE0  = 8;
    localparam int PB_SYN  = 15;
    localparam int PB_WDT  = 16;
    localparam int PB_RMON = 17;

    // XIR cause bit positions
    localparam int XB_JTAG = 4;
    localparam int XB_BTN  = 5;

    typedef struct packed {
        logic            sys;
        logic [NCPU-1:0] cpu;
    } rst_tgt_t;

    // which outputs a POR event drives: any source above the per-cpu bits is system-wide
    function automatic rst_tgt_t por_target(input logic [POR_CW-1:0] ev);
        rst_tgt_t t;
        t.sys = |ev[POR_CW-1:NCPU];
        t.cpu = t.sys ? {NCPU{1'b1}} : ev[NCPU-1:0];
        return t;
    endfunction

    function automatic logic [NCPU-1:0] xir_target(input logic [XIR_CW-1:0] ev);
        return (|ev[XIR_CW-1:NCPU]) ? {NCPU{1'b1}} : ev[NCPU-1:0];
    endfunction

    // power-up overrides every other cause bit
    function automatic logic [POR_CW-1:0] por_cause(input logic [POR_CW-1:0] ev);
        return ev[PB_PWR] ? (POR_CW'(1) << PB_PWR) : ev;
    endfunction

endpackage

// File: rtl/rcc_edge.sv
module rcc_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse #(
    parameter int PULSE_W = 16,
    parameter int TW      = 5,
    parameter int CW      = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [TW-1:0] tgt_in,
    input  logic [CW-1:0] cause_in,
    output logic          busy,
    output logic          start,
    output logic          last,
    output logic [TW-1:0] tgt_out,
    output logic [CW-1:0] cause_out
);
    localparam int CNT_W = $clog2(PULSE_W + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [TW-1:0]    tgt_q;
    logic [CW-1:0]    cause_q;

    assign busy  = (cnt_q != '0);
    assign last  = (cnt_q == CNT_W'(1));
    assign start = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            tgt_q   <= '0;
            cause_q <= '0;
        end else if (start) begin
            cnt_q   <= CNT_W'(PULSE_W);
            tgt_q   <= tgt_in;
            cause_q <= cause_in;
        end else if (busy) begin
            cnt_q   <= cnt_q - CNT_W'(1);
        end
    end

    assign tgt_out   = busy ? tgt_q : '0;
    assign cause_out = cause_q;

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> busy && $stable(cause_out) && $stable(tgt_out));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && (tgt_out == $past(tgt_in)));

    // R2
    end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(last));
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int PULSE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              wdog_i,
    input  logic              rst_btn_i,
    input  logic              xir_btn_i,
    input  logic              jtag_por_i,
    input  logic              jtag_xir_i,
    input  logic              pwr_up_i,
    input  logic [NFATAL-1:0] fatal_i,
    input  logic              rmon_i,
    output logic [NCPU-1:0]   por_o,
    output logic [NCPU-1:0]   xir_o,
    output logic              sys_rst_o
);
    // edge-detector lane map
    localparam int L_JX = 0;
    localparam int L_XB = 1;
    localparam int L_FE = 2;
    localparam int L_JP = L_FE + NFATAL;
    localparam int L_RB = L_JP + 1;
    localparam int L_PU = L_RB + 1;
    localparam int L_WD = L_PU + 1;
    localparam int L_RM = L_WD + 1;
    localparam int L_SY = L_RM + 1;
    localparam int LW   = L_SY + 1;
    localparam int TW   = NCPU + 1;

    // configuration state
    logic            wd_pol_q;
    logic [7:0]      qui_q;
    logic            syn_arm_q, syn_load_q;
    logic [TW-1:0]   spor_q;
    logic [NCPU-1:0] sxir_q;

    // edges
    logic [LW-1:0]     lvl, rise;
    logic [NFATAL-1:0] fat_ok;
    logic [NCPU-1:0]   qmask;

    assign lvl   = {syn_arm_q & syn_load_q, rmon_i, wdog_i, pwr_up_i, rst_btn_i,
                    jtag_por_i, fatal_i, xir_btn_i, jtag_xir_i};
    assign qmask = qui_q[7:4];

    rcc_edge #(.W(LW)) u_edge (.clk(clk), .rst(rst), .lvl(lvl), .rise(rise));

    for (genvar g = 0; g < NFATAL; g++) begin : g_fat
        if (g < NCPU) begin : g_maskable
            assign fat_ok[g] = rise[L_FE+g] & ~qmask[g];
        end else begin : g_fixed
            assign fat_ok[g] = rise[L_FE+g];
        end
    end

    // event vectors
    logic              wr_spor, wr_sxir;
    logic [POR_CW-1:0] por_ev;
    logic [XIR_CW-1:0] xir_ev;
    rst_tgt_t          por_tin, por_tgt;
    logic [TW-1:0]     por_tout;
    logic [POR_CW-1:0] por_cause_q;
    logic [XIR_CW-1:0] xir_cause_q;
    logic              por_busy, por_start, por_last;
    logic              xir_busy, xir_start, xir_last;

    assign wr_spor = reg_we && (reg_addr == A_SPOR);
    assign wr_sxir = reg_we && (reg_addr == A_SXIR);

    always_comb begin
        por_ev = '0;
        if (wr_spor) por_ev[PB_SYS:0] = reg_wdata[PB_SYS:0];
        por_ev[PB_JTAG]                 = rise[L_JP];
        por_ev[PB_BTN]                  = rise[L_RB];
        por_ev[PB_PWR]                  = rise[L_PU];
        por_ev[PB_FE0 +: NFATAL]        = fat_ok;
        por_ev[PB_SYN]                  = rise[L_SY];
        por_ev[PB_WDT]                  = rise[L_WD] & wd_pol_q;
        por_ev[PB_RMON]                 = rise[L_RM];

        xir_ev = '0;
        if (wr_sxir) xir_ev[NCPU-1:0] = reg_wdata[NCPU-1:0];
        xir_ev[XB_JTAG] = rise[L_JX];
        xir_ev[XB_BTN]  = rise[L_XB];
    end

    assign por_tin = por_target(por_ev);

    rcc_pulse #(.PULSE_W(PULSE_W), .TW(TW), .CW(POR_CW)) u_por (
        .clk(clk), .rst(rst), .req(|por_ev), .tgt_in(por_tin),
        .cause_in(por_cause(por_ev)), .busy(por_busy), .start(por_start),
        .last(por_last), .tgt_out(por_tout), .cause_out(por_cause_q));

    rcc_pulse #(.PULSE_W(PULSE_W), .TW(NCPU), .CW(XIR_CW)) u_xir (
        .clk(clk), .rst(rst), .req(|xir_ev), .tgt_in(xir_target(xir_ev)),
        .cause_in(xir_ev), .busy(xir_busy), .start(xir_start),
        .last(xir_last), .tgt_out(xir_o), .cause_out(xir_cause_q));

    assign por_tgt   = por_tout;
    assign por_o     = por_tgt.cpu;
    assign sys_rst_o = por_tgt.sys;

    // register state
    always_ff @(posedge clk) begin
        if (rst) begin
            wd_pol_q   <= 1'b0;
            qui_q      <= '0;
            syn_arm_q  <= 1'b0;
            syn_load_q <= 1'b0;
            spor_q     <= '0;
            sxir_q     <= '0;
        end else begin
            if (reg_we && reg_addr == A_WDOG) wd_pol_q <= reg_wdata[0];
            if (reg_we && reg_addr == A_QUI)  qui_q    <= reg_wdata;
            if (reg_we && reg_addr == A_SYN) begin
                syn_arm_q  <= reg_wdata[7];
                syn_load_q <= reg_wdata[0];
            end
            if (por_start)     spor_q <= wr_spor ? reg_wdata[TW-1:0] : '0;
            else if (por_last) spor_q <= '0;
            if (xir_start)     sxir_q <= wr_sxir ? reg_wdata[NCPU-1:0] : '0;
            else if (xir_last) sxir_q <= '0;
        end
    end

    // read mux
    always_comb begin
        case (reg_addr)
            A_WDOG:  reg_rdata = {7'd0, wd_pol_q};
            A_QUI:   reg_rdata = qui_q;
            A_SPOR:  reg_rdata = 8'(spor_q);
            A_SXIR:  reg_rdata = 8'(sxir_q);
            A_SYN:   reg_rdata = {syn_arm_q, 6'd0, syn_load_q};
            A_PC0:   reg_rdata = por_cause_q[7:0];
            A_PC1:   reg_rdata = por_cause_q[15:8];
            A_PC2:   reg_rdata = 8'(por_cause_q[POR_CW-1:16]);
            A_XC:    reg_rdata = 8'(xir_cause_q);
            default: reg_rdata = 8'd0;
        endcase
    end

    // R3
    sys_all_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> (&por_o));

    // R6
    wdog_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !por_busy && rise[L_WD] && !wd_pol_q && (por_ev == '0) |=> !sys_rst_o);

    // R8
    fatal_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !por_busy && (|(rise[L_FE +: NCPU] & qmask))
        |=> ((por_cause_q[PB_FE0 +: NCPU] & $past(qmask)) == '0));

    // R10
    pwrup_chk: assert property (@(posedge clk) disable iff (rst)
        !por_busy && rise[L_PU] |=> sys_rst_o && (por_cause_q == (POR_CW'(1) << PB_PWR)));

    // R4
    xir_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !xir_busy |-> (xir_o == '0));
endmodule

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;
    localparam int PW = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       wdog = 0, rbtn = 0, xbtn = 0, jpor = 0, jxir = 0, pwr = 0, rmon = 0;
    logic [6:0] fat = '0;
    logic [3:0] por, xir;
    logic       sysr;

    always #10 clk = ~clk;  // 50 MHz

    reset_cause_ctrl #(.PULSE_W(PW)) uut (
        .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .wdog_i(wdog), .rst_btn_i(rbtn), .xir_btn_i(xbtn),
        .jtag_por_i(jpor), .jtag_xir_i(jxir), .pwr_up_i(pwr), .fatal_i(fat),
        .rmon_i(rmon), .por_o(por), .xir_o(xir), .sys_rst_o(sysr));

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit started = 0, done = 0;

    // behavioural reference model
    int m_pol, m_qm, m_arm, m_load, m_spor, m_sxir;
    int m_pcnt, m_pcpu, m_psys, m_pcause, m_xcnt, m_xcpu, m_xcause;
    int p_wd, p_rb, p_xb, p_jp, p_jx, p_pu, p_rm, p_syn, p_fat;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_pol = 0; m_qm = 0; m_arm = 0; m_load = 0; m_spor = 0; m_sxir = 0;
            m_pcnt = 0; m_pcpu = 0; m_psys = 0; m_pcause = 0;
            m_xcnt = 0; m_xcpu = 0; m_xcause = 0;
            p_wd = 0; p_rb = 0; p_xb = 0; p_jp = 0; p_jx = 0; p_pu = 0; p_rm = 0;
            p_syn = 0; p_fat = 0;
        end else begin
            int pev, xev, syn_c, fr;
            syn_c = m_arm & m_load;
            pev = 0; xev = 0;
            if (we && addr == 2) pev |= wdata & 'h1f;
            if (jpor && !p_jp) pev |= 1 << 5;
            if (rbtn && !p_rb) pev |= 1 << 6;
            if (pwr && !p_pu)  pev |= 1 << 7;
            fr = fat & ~p_fat;
            for (int k = 0; k < 7; k++)
                if (fr[k] && !(k < 4 && ((m_qm >> (4 + k)) & 1))) pev |= 1 << (8 + k);
            if (syn_c && !p_syn) pev |= 1 << 15;
            if (wdog && !p_wd && m_pol) pev |= 1 << 16;
            if (rmon && !p_rm) pev |= 1 << 17;
            if (we && addr == 3) xev |= wdata & 'hf;
            if (jxir && !p_jx) xev |= 1 << 4;
            if (xbtn && !p_xb) xev |= 1 << 5;

            if (m_pcnt == 0) begin
                if (pev != 0) begin
                    m_pcause = (pev & 'h80) ? 'h80 : pev;
                    m_psys = ((pev >> 4) != 0) ? 1 : 0;
                    m_pcpu = m_psys ? 15 : (pev & 15);
                    m_pcnt = PW;
                    m_spor = (we && addr == 2) ? (wdata & 'h1f) : 0;
                end
            end else begin
                m_pcnt--;
                if (m_pcnt == 0) m_spor = 0;
            end
            if (m_xcnt == 0) begin
                if (xev != 0) begin
                    m_xcause = xev;
                    m_xcpu = ((xev >> 4) != 0) ? 15 : (xev & 15);
                    m_xcnt = PW;
                    m_sxir = (we && addr == 3) ? (wdata & 'hf) : 0;
                end
            end else begin
                m_xcnt--;
                if (m_xcnt == 0) m_sxir = 0;
            end
            if (we && addr == 0) m_pol = wdata & 1;
            if (we && addr == 1) m_qm = wdata;
            if (we && addr == 4) begin m_arm = (wdata >> 7) & 1; m_load = wdata & 1; end
            p_wd = wdog; p_rb = rbtn; p_xb = xbtn; p_jp = jpor; p_jx = jxir;
            p_pu = pwr; p_rm = rmon; p_syn = syn_c; p_fat = fat;
        end
    end

    function automatic int mrd(int a);
        case (a)
            0: return m_pol;
            1: return m_qm;
            2: return m_spor;
            3: return m_sxir;
            4: return (m_arm << 7) | m_load;
            5: return m_pcause & 255;
            6: return (m_pcause >> 8) & 255;
            7: return (m_pcause >> 16) & 3;
            8: return m_xcause;
            default: return 0;
        endcase
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int ep, ex, es, er;
            ep = (m_pcnt > 0) ? m_pcpu : 0;
            ex = (m_xcnt > 0) ? m_xcpu : 0;
            es = (m_pcnt > 0) ? m_psys : 0;
            er = mrd(int'(addr));
            checks++;
            if (int'(por) != ep || int'(xir) != ex || int'(sysr) != es || int'(rdata) != er) begin
                errors++;
                $display("FAIL %s: actual por=%h xir=%h sys=%0d rd[%0d]=%h expected por=%h xir=%h sys=%0d rd=%h",
                         cur_req, por, xir, sysr, addr, rdata, ep, ex, es, er);
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic wr(int a, int d);
        we = 1; addr = 4'(a); wdata = 8'(d);
        cyc(1);
        we = 0;
    endtask

    // wait out a pulse while sweeping the readable registers
    task automatic settle();
        addr = 4'h5; cyc(6);
        addr = 4'h6; cyc(6);
        addr = 4'h7; cyc(6);
        addr = 4'h8; cyc(4);
        addr = 4'h2; cyc(1);
        addr = 4'h3; cyc(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still going, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        // R1 reset state on every address
        cur_req = "R1";
        for (int a = 0; a < 16; a++) begin addr = 4'(a); cyc(1); end
        // R2 per-cpu soft POR, readback during pulse
        cur_req = "R2";
        wr(2, 'h05); addr = 4'h2; cyc(4); settle();
        wr(2, 'h0a); settle();
        // R3 system soft POR
        cur_req = "R3";
        wr(2, 'h1f); settle();
        // R4 soft XIR
        cur_req = "R4";
        wr(3, 'h09); addr = 4'h3; cyc(3); settle();
        // R5 JTAG XIR, button XIR, both together with a soft write (R11)
        cur_req = "R5";
        jxir = 1; cyc(1); jxir = 0; settle();
        xbtn = 1; cyc(1); xbtn = 0; settle();
        cur_req = "R11";
        jxir = 1; xbtn = 1; wr(3, 'h02); jxir = 0; xbtn = 0; settle();
        // R6 watchdog ignored, then enabled
        cur_req = "R6";
        wdog = 1; cyc(2); wdog = 0; settle();
        wr(0, 'h01); addr = 4'h0; cyc(1);
        wdog = 1; cyc(2); wdog = 0; settle();
        wr(0, 'h00);
        // R7 individual system sources
        cur_req = "R7";
        jpor = 1; cyc(1); jpor = 0; settle();
        rbtn = 1; cyc(1); rbtn = 0; settle();
        rmon = 1; cyc(1); rmon = 0; settle();
        for (int k = 0; k < 7; k++) begin fat[k] = 1; cyc(1); fat[k] = 0; settle(); end
        // R8 quiesce masks fatal 0..3 only
        cur_req = "R8";
        wr(1, 'hf3); addr = 4'h1; cyc(1);
        for (int k = 0; k < 4; k++) begin fat[k] = 1; cyc(1); fat[k] = 0; settle(); end
        fat[4] = 1; cyc(1); fat[4] = 0; settle();
        wr(1, 'h20); fat = 7'h03; cyc(1); fat = '0; settle();
        wr(1, 'h00);
        // R9 clock-synth armed load
        cur_req = "R9";
        wr(4, 'h80); addr = 4'h4; cyc(3);
        wr(4, 'h81); addr = 4'h4; cyc(2); settle();
        wr(4, 'h00); cyc(2);
        // R10 power-up wins the cause
        cur_req = "R10";
        pwr = 1; jpor = 1; fat[5] = 1; cyc(1); pwr = 0; jpor = 0; fat[5] = 0; settle();
        // R11 simultaneous sources union
        cur_req = "R11";
        rbtn = 1; rmon = 1; cyc(1); rbtn = 0; rmon = 0; settle();
        jpor = 1; wr(2, 'h03); jpor = 0; settle();
        // R12 busy drops new events of the same kind
        cur_req = "R12";
        wr(2, 'h01); cyc(3); wr(2, 'h02); rmon = 1; cyc(1); rmon = 0;
        addr = 4'h2; cyc(2); settle();
        wr(3, 'h04); cyc(2); jxir = 1; cyc(1); jxir = 0; settle();
        // R13 readback of unused addresses
        cur_req = "R13";
        for (int a = 9; a < 16; a++) begin addr = 4'(a); cyc(1); end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule